// File: doc/BRIEF.md
# Control Link Decoder for Procedure Call

This block resolves a one-word control link into the full context a call or a return needs: the destination global frame, the 32-bit code base, the starting program counter and, for a procedure entry, a frame-size index. Bit 0 of the link is a tag. An even link is a local frame pointer. An odd link is a packed procedure descriptor, which is expanded by reading three linkage tables in turn.

For a descriptor, the decoder reads the global frame table slot that the link names. That slot gives the global frame address, and its two low bits give an entry-index bias. The decoder then reads the code base from the global frame. Last, it reads the procedure's entry from the entry vector at the start of the code segment. For a frame link, it reads the global frame and the saved program counter from the local frame, and then reads the code base through that global frame.

All reads use one word-addressed, single-port memory interface with a one-cycle read latency. Short pointers are offsets from a main data space base, which is an input. The table base is also an input. A caller pulses `start_i` while the block is idle and waits for the one-cycle `done_o`.

Top module: `ctl_link_decoder`

## Requirements
- R1: At done, `is_proc_o` equals bit 0 of the accepted link: 1 for a procedure descriptor, 0 for a local frame pointer.
- R2: For a descriptor, the table slot read is at `gft_base_i` + link[15:6]. `gf_o` is that slot's word with bits 1:0 forced to 0.
- R3: For a descriptor, the effective entry index is link[5:1] + 32 × slot[1:0], which ranges from 0 to 127. `pc_o` is the word at code base + 2 × index. `fsi_o` is the low 8 bits of the word at code base + 2 × index + 1.
- R4: `cb_o` is {word at `mds_base_i` + gf + 1, word at `mds_base_i` + gf}. The low half is at the lower address.
- R5: For a frame link, `gf_o` is the word at `mds_base_i` + link, `pc_o` is the word at `mds_base_i` + link + 1, `cb_o` follows R4 through that gf, and `fsi_o` is 0.
- R6: Each read takes two cycles. `done_o` is a one-cycle pulse that comes 10 clock edges after the accepting edge for a descriptor and 8 clock edges after it for a frame link. `busy_o` is high from the accepting edge until done, and it is low while `done_o` is high.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The results of the running operation are unchanged, and no extra operation follows.
- R8: During reset, `busy_o`, `done_o` and `mem_req_o` are low, and all result outputs are zero.
- R9: `mem_req_o` is never high in two consecutive cycles. It is high exactly 5 times per descriptor and 4 times per frame link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| link_i | input | 16 | Control link to decode |
| gft_base_i | input | 32 | Word address of the global frame table |
| mds_base_i | input | 32 | Main data space base that short pointers are added to |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse; all results are valid |
| is_proc_o | output | 1 | Link was a procedure descriptor |
| gf_o | output | 16 | Destination global frame (short pointer) |
| cb_o | output | 32 | Destination code base |
| pc_o | output | 16 | Starting or saved program counter |
| fsi_o | output | 8 | Frame-size index (0 for a frame link) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory word address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the request |

## Verification
The bench builds the block with its default widths: a 16-bit word, a 5-bit entry field, a 2-bit bias and an 8-bit frame-size index. With these values, all 1024 table slots and all 128 effective entry indexes can be reached. The bench also drives every bias value, including the top index of 127. Random descriptor and frame links run against a memory image in which every pointer lands inside the modelled space. This lets the bench recompute each table walk from the requirements. A mid-operation start pulse exercises the rule that a start is ignored while busy.

// File: rtl/clink_pkg.sv
package clink_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_CAPT
  } phase_e;

  typedef enum logic [2:0] {
    STP_GFT,
    STP_LF_GF,
    STP_LF_PC,
    STP_CB_LO,
    STP_CB_HI,
    STP_EV_PC,
    STP_EV_FSI
  } step_e;

  function automatic step_e first_step(logic desc);
    return desc ? STP_GFT : STP_LF_GF;
  endfunction

  function automatic logic last_step(step_e s, logic desc);
    return desc ? (s == STP_EV_FSI) : (s == STP_CB_HI);
  endfunction

  function automatic step_e next_step(step_e s);
    case (s)
      STP_GFT:   return STP_CB_LO;
      STP_LF_GF: return STP_LF_PC;
      STP_LF_PC: return STP_CB_LO;
      STP_CB_LO: return STP_CB_HI;
      STP_CB_HI: return STP_EV_PC;
      STP_EV_PC: return STP_EV_FSI;
      default:   return STP_GFT;
    endcase
  endfunction

endpackage

// File: rtl/clink_classify.sv
module clink_classify #(
  parameter int WORD_W = 16,
  parameter int EP_W   = 5,
  localparam int IDX_W = WORD_W - EP_W - 1
) (
  input  logic [WORD_W-1:0] link_i,
  output logic              is_desc_o,
  output logic [EP_W-1:0]   ep_o,
  output logic [IDX_W-1:0]  gft_idx_o
);
  // Frame pointers are even; descriptors are odd
  assign is_desc_o = link_i[0];
  assign ep_o      = link_i[EP_W:1];
  assign gft_idx_o = link_i[WORD_W-1:EP_W+1];
endmodule

// File: rtl/clink_addr_gen.sv
module clink_addr_gen
  import clink_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EP_W   = 5,
  parameter int BIAS_W = 2,
  localparam int IDX_W  = WORD_W - EP_W - 1,
  localparam int EPX_W  = EP_W + BIAS_W,
  localparam int ADDR_W = 2 * WORD_W
) (
  input  step_e             step_i,
  input  logic [ADDR_W-1:0] gft_base_i,
  input  logic [ADDR_W-1:0] mds_base_i,
  input  logic [IDX_W-1:0]  gft_idx_i,
  input  logic [WORD_W-1:0] fp_i,
  input  logic [WORD_W-1:0] gf_i,
  input  logic [ADDR_W-1:0] cb_i,
  input  logic [EPX_W-1:0]  epx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] lf_addr, gf_addr, ev_addr;

  assign lf_addr = mds_base_i + ADDR_W'(fp_i);
  assign gf_addr = mds_base_i + ADDR_W'(gf_i);
  // Entry vector slots are two words wide
  assign ev_addr = cb_i + ADDR_W'({epx_i, 1'b0});

  always_comb begin
    case (step_i)
      STP_GFT:    addr_o = gft_base_i + ADDR_W'(gft_idx_i);
      STP_LF_GF:  addr_o = lf_addr;
      STP_LF_PC:  addr_o = lf_addr + ADDR_W'(1);
      STP_CB_LO:  addr_o = gf_addr;
      STP_CB_HI:  addr_o = gf_addr + ADDR_W'(1);
      STP_EV_PC:  addr_o = ev_addr;
      STP_EV_FSI: addr_o = ev_addr + ADDR_W'(1);
      default:    addr_o = '0;
    endcase
  end
endmodule

// File: rtl/clink_seq.sv
module clink_seq
  import clink_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EP_W   = 5,
  parameter int BIAS_W = 2,
  parameter int FSI_W  = 8,
  localparam int EPX_W = EP_W + BIAS_W,
  localparam int CB_W  = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] link_i,
  input  logic              desc_i,
  input  logic [EP_W-1:0]   ep_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              req_o,
  output logic              done_o,
  output step_e             step_o,
  output logic [WORD_W-1:0] link_q_o,
  output logic              desc_q_o,
  output logic [WORD_W-1:0] gf_q_o,
  output logic [CB_W-1:0]   cb_q_o,
  output logic [WORD_W-1:0] pc_q_o,
  output logic [FSI_W-1:0]  fsi_q_o,
  output logic [EPX_W-1:0]  epx_q_o
);
  phase_e phase_q;
  step_e  step_q;
  logic   done_q;

  assign busy_o = (phase_q != PH_IDLE);
  assign req_o  = (phase_q == PH_ISSUE);
  assign done_o = done_q;
  assign step_o = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      step_q   <= STP_GFT;
      done_q   <= 1'b0;
      link_q_o <= '0;
      desc_q_o <= 1'b0;
      gf_q_o   <= '0;
      cb_q_o   <= '0;
      pc_q_o   <= '0;
      fsi_q_o  <= '0;
      epx_q_o  <= '0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            link_q_o <= link_i;
            desc_q_o <= desc_i;
            step_q   <= first_step(desc_i);
            fsi_q_o  <= '0;
            epx_q_o  <= '0;
            phase_q  <= PH_ISSUE;
          end
        end
        PH_ISSUE: phase_q <= PH_CAPT;
        PH_CAPT: begin
          case (step_q)
            STP_GFT: begin
              // Quad alignment frees two bits for the entry bias
              gf_q_o  <= {rdata_i[WORD_W-1:BIAS_W], {BIAS_W{1'b0}}};
              epx_q_o <= {rdata_i[BIAS_W-1:0], ep_i};
            end
            STP_LF_GF:  gf_q_o <= rdata_i;
            STP_LF_PC:  pc_q_o <= rdata_i;
            STP_CB_LO:  cb_q_o[WORD_W-1:0] <= rdata_i;
            STP_CB_HI:  cb_q_o[CB_W-1:WORD_W] <= rdata_i;
            STP_EV_PC:  pc_q_o <= rdata_i;
            STP_EV_FSI: fsi_q_o <= rdata_i[FSI_W-1:0];
            default: ;
          endcase
          if (last_step(step_q, desc_q_o)) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            step_q  <= next_step(step_q);
            phase_q <= PH_ISSUE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_req_spaced_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  assert_req_in_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);
  assert_frame_steps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !desc_q_o) |-> (step_o inside {STP_LF_GF, STP_LF_PC, STP_CB_LO, STP_CB_HI}));
endmodule

// File: rtl/ctl_link_decoder.sv
module ctl_link_decoder
  import clink_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EP_W   = 5,
  parameter int BIAS_W = 2,
  parameter int FSI_W  = 8,
  localparam int IDX_W  = WORD_W - EP_W - 1,
  localparam int EPX_W  = EP_W + BIAS_W,
  localparam int CB_W   = 2 * WORD_W,
  localparam int ADDR_W = CB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] link_i,
  input  logic [ADDR_W-1:0] gft_base_i,
  input  logic [ADDR_W-1:0] mds_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              is_proc_o,
  output logic [WORD_W-1:0] gf_o,
  output logic [CB_W-1:0]   cb_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [FSI_W-1:0]  fsi_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  logic              busy;
  logic [WORD_W-1:0] link_q, cls_link, gf_q, pc_q;
  logic [CB_W-1:0]   cb_q;
  logic [FSI_W-1:0]  fsi_q;
  logic [EPX_W-1:0]  epx_q;
  logic              desc_q, cls_desc;
  logic [EP_W-1:0]   cls_ep;
  logic [IDX_W-1:0]  cls_idx;
  step_e             step;

  // One decoder: live link when idle, latched link during the walk
  assign cls_link = busy ? link_q : link_i;

  clink_classify #(.WORD_W(WORD_W), .EP_W(EP_W)) u_cls (
    .link_i    (cls_link),
    .is_desc_o (cls_desc),
    .ep_o      (cls_ep),
    .gft_idx_o (cls_idx)
  );

  clink_seq #(.WORD_W(WORD_W), .EP_W(EP_W), .BIAS_W(BIAS_W), .FSI_W(FSI_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .link_i   (link_i),
    .desc_i   (cls_desc),
    .ep_i     (cls_ep),
    .rdata_i  (mem_rdata_i),
    .busy_o   (busy),
    .req_o    (mem_req_o),
    .done_o   (done_o),
    .step_o   (step),
    .link_q_o (link_q),
    .desc_q_o (desc_q),
    .gf_q_o   (gf_q),
    .cb_q_o   (cb_q),
    .pc_q_o   (pc_q),
    .fsi_q_o  (fsi_q),
    .epx_q_o  (epx_q)
  );

  clink_addr_gen #(.WORD_W(WORD_W), .EP_W(EP_W), .BIAS_W(BIAS_W)) u_addr (
    .step_i     (step),
    .gft_base_i (gft_base_i),
    .mds_base_i (mds_base_i),
    .gft_idx_i  (cls_idx),
    .fp_i       (link_q),
    .gf_i       (gf_q),
    .cb_i       (cb_q),
    .epx_i      (epx_q),
    .addr_o     (mem_addr_o)
  );

  assign busy_o    = busy;
  assign is_proc_o = desc_q;
  assign gf_o      = gf_q;
  assign cb_o      = cb_q;
  assign pc_o      = pc_q;
  assign fsi_o     = fsi_q;

  assert_gf_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_proc_o) |-> (gf_o[BIAS_W-1:0] == '0));
  assert_fsi_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !is_proc_o) |-> (fsi_o == '0));
  assert_kind_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(is_proc_o));
endmodule

// File: tb/ctl_link_decoder_bench.sv
module ctl_link_decoder_bench;
  localparam logic [31:0] MDS_BASE = 32'h0003_0000;
  localparam logic [31:0] GFT_BASE = 32'h0005_0800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] link_in = '0;
  logic        busy, done, is_proc, mem_req;
  logic [15:0] gf, pc, mem_rdata;
  logic [31:0] cb, mem_addr;
  logic [7:0]  fsi;

  logic [15:0] mem [0:4095];
  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int req_back = 0;
  logic req_prev = 1'b0;

  logic        e_proc;
  logic [15:0] e_gf, e_pc;
  logic [31:0] e_cb;
  logic [7:0]  e_fsi;
  int          e_reads;

  always #2.5 clk = ~clk;

  ctl_link_decoder u_ctl_link_decoder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .link_i(link_in),
    .gft_base_i(GFT_BASE), .mds_base_i(MDS_BASE),
    .busy_o(busy), .done_o(done), .is_proc_o(is_proc), .gf_o(gf),
    .cb_o(cb), .pc_o(pc), .fsi_o(fsi),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  // Single-port memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem[mem_addr[11:0]];
      req_cnt <= req_cnt + 1;
    end
    if (mem_req && req_prev) req_back <= req_back + 1;
    req_prev <= mem_req;
  end

  function automatic logic [15:0] rd(input logic [31:0] a);
    return mem[a[11:0]];
  endfunction

  function automatic void expect_for(input logic [15:0] l);
    logic [15:0] ent;
    logic [6:0]  idx;
    logic [31:0] ev;
    if (l[0]) begin
      ent = rd(GFT_BASE + 32'(l[15:6]));
      e_gf = ent & 16'hFFFC;
      idx = {ent[1:0], l[5:1]};
      e_cb = {rd(MDS_BASE + 32'(e_gf) + 1), rd(MDS_BASE + 32'(e_gf))};
      ev = e_cb + 32'(idx) * 2;
      e_pc = rd(ev);
      e_fsi = rd(ev + 1) & 8'hFF;
      e_reads = 5;
    end else begin
      e_gf = rd(MDS_BASE + 32'(l));
      e_pc = rd(MDS_BASE + 32'(l) + 1);
      e_cb = {rd(MDS_BASE + 32'(e_gf) + 1), rd(MDS_BASE + 32'(e_gf))};
      e_fsi = 8'h00;
      e_reads = 4;
    end
    e_proc = l[0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] l, input int poke_at, input logic [15:0] poke_link);
    int lat;
    expect_for(l);
    @(negedge clk);
    req_cnt = 0;
    start = 1'b1;
    link_in = l;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk(busy == 1'b1, "R6 busy after accept", 64'(busy), 64'd1);
    while (!done && lat < 60) begin
      if (lat == poke_at) begin
        start = 1'b1;
        link_in = poke_link;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(done == 1'b1, "R6 done reached", 64'(done), 64'd1);
    chk(lat == 2 * e_reads, "R6 latency", 64'(lat), 64'(2 * e_reads));
    chk(is_proc == e_proc, "R1 tag", 64'(is_proc), 64'(e_proc));
    chk(gf == e_gf, e_proc ? "R2 global frame" : "R5 global frame", 64'(gf), 64'(e_gf));
    chk(cb == e_cb, "R4 code base", 64'(cb), 64'(e_cb));
    chk(pc == e_pc, e_proc ? "R3 pc" : "R5 pc", 64'(pc), 64'(e_pc));
    chk(fsi == e_fsi, e_proc ? "R3 fsi" : "R5 fsi", 64'(fsi), 64'(e_fsi));
    chk(req_cnt == e_reads, "R9 read count", 64'(req_cnt), 64'(e_reads));
    chk(busy == 1'b0, "R6 idle at done", 64'(busy), 64'd0);
  endtask

  function automatic logic [15:0] rnd_desc();
    logic [31:0] r = $urandom;
    return {r[9:0], r[14:10], 1'b1};
  endfunction

  function automatic logic [15:0] rnd_frame();
    logic [31:0] r = $urandom;
    return {r[15:12], 2'b01, r[8:0], 1'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 4096; a++) begin
      logic [31:0] r = $urandom;
      if (a < 'h400)      mem[a] = {r[15:12], 4'hC, r[7:0]};
      else if (a < 'h800) mem[a] = a[0] ? r[15:0] : {r[15:12], 2'b00, r[9:1], 1'b0};
      else if (a < 'hC00) mem[a] = {r[15:12], 2'b00, r[9:0]};
      else                mem[a] = r[15:0];
    end

    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 0 && done == 0 && mem_req == 0, "R8 reset controls", {busy, done, mem_req}, 0);
    chk(gf == 0 && pc == 0 && cb == 0 && fsi == 0 && is_proc == 0, "R8 reset results",
        {is_proc, gf, pc, fsi}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 every bias value, entry field at its top
    for (int b = 0; b < 4; b++) begin
      mem[12'h805] = 16'h0100 | 16'(b);
      run_op({10'd5, 5'd31, 1'b1}, -1, 16'h0);
    end
    mem[12'h800] = 16'h0000;
    run_op({10'd0, 5'd0, 1'b1}, -1, 16'h0);
    // R5 frame links at region edges
    run_op(16'h0400, -1, 16'h0);
    run_op(16'hF7FE, -1, 16'h0);

    // R7 start while busy is ignored
    begin
      logic [15:0] first_l = rnd_desc();
      run_op(first_l, 3, rnd_frame());
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        chk(done == 0 && busy == 0, "R7 no extra operation", {done, busy}, 0);
      end
      expect_for(first_l);
      chk(gf == e_gf && pc == e_pc && cb == e_cb, "R7 results held", 64'(pc), 64'(e_pc));
    end
    run_op(rnd_frame(), 5, rnd_desc());

    for (int n = 0; n < 300; n++) begin
      if ($urandom % 2) run_op(rnd_desc(), -1, 16'h0);
      else              run_op(rnd_frame(), -1, 16'h0);
    end

    chk(req_back == 0, "R9 no back-to-back reads", 64'(req_back), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule